// File: doc/BRIEF.md
# Closed-Loop Multi-Cycle Word Handoff

This block carries a multi-bit word from a source clock domain to an unrelated destination clock domain. It does not synchronize the data bits. The source side keeps the word in a holding register. It turns a one-cycle send request into a change of level on a single request toggle. Only that toggle goes through a flip-flop synchronizer into the destination clock. There, an edge detector on the synchronized toggle produces a load pulse. The pulse captures the held word, which by then has been stable for several destination cycles.

The destination always accepts. Its registered copy of the toggle goes back through a second synchronizer to the source as an acknowledge. A two-state controller on the source side uses the acknowledge to raise its ready flag again. Logic on the source side waits for `src_ready`, then pulses `src_send` with the word on `src_word`. Logic on the destination side uses `dst_word` whenever `dst_valid` pulses.

Top module: `mcp_handoff`

## Requirements
- R1: The word captured into `dst_word` equals the word held by the source at the moment of capture. That held word does not change between the request toggle and the capture.
- R2: `dst_word` changes only together with a one-cycle `dst_valid` pulse. Every accepted send produces exactly one such pulse.
- R3: A send is accepted when `src_send` is 1 while `src_ready` is 1. `src_ready` is 0 in the source cycle after the accepted send, and the request toggle flips.
- R4: After an accepted send, `src_ready` returns to 1 within a bounded number of source cycles, once the acknowledge toggle matches the request toggle. The next send is then accepted.
- R5: A send presented while `src_ready` is 0 is ignored. It does not flip the request toggle, does not produce a `dst_valid` pulse, and does not alter the word that is delivered.
- R6: The source loads its holding register only on an accepted send. Changes on `src_word` while a transfer is in flight do not affect the delivered word.
- R7: After reset, `src_ready` is 1, `dst_valid` is 0 and `dst_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous |
| src_send | input | 1 | One-cycle request to transfer `src_word` |
| src_word | input | WIDTH | Word offered by the source |
| src_ready | output | 1 | High when a new send will be accepted |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, asynchronous |
| dst_word | output | WIDTH | Last word captured in the destination domain |
| dst_valid | output | 1 | One-cycle pulse when `dst_word` has just been updated |

## Verification
On every clock, the assertions check the following:
- on the source clock: ready drops after an accepted send, the toggle flips on that send and not on an ignored one, and the holding register stays frozen while ready is low;
- on the destination clock: the output word moves only under a single-cycle valid pulse, and that pulse coincides with the output equalling the source's held word.

The bench scenarios cover what no single-cycle property can. They check that each send yields exactly one delivery, with the right value, across two unrelated clock periods. They check that ready comes back within a bounded time. They also check that sends while busy, or noise on the input word during a transfer, leave the delivered values unchanged.

// File: rtl/mcp_handoff_pkg.sv
`timescale 1ns/1ps
package mcp_handoff_pkg;

    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_BUSY = 1'b1
    } src_state_e;

    typedef struct packed {
        src_state_e state;
        logic       req_tog;
        logic       ack_seen;
    } src_ctl_t;

    typedef struct packed {
        logic seen;
        logic load;
    } dst_ctl_t;

endpackage

// File: rtl/mcp_sync.sv
`timescale 1ns/1ps
module mcp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d;
    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[LAST];
endmodule

// File: rtl/mcp_src_ctrl.sv
`timescale 1ns/1ps
module mcp_src_ctrl
    import mcp_handoff_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send,
    input  logic [WIDTH-1:0] word,
    input  logic             ack_tog_async,
    output logic             ready,
    output logic             req_tog,
    output logic [WIDTH-1:0] held_word
);
    src_ctl_t         ctl_d, ctl_q;
    logic [WIDTH-1:0] held_d, held_q;
    logic             ack_s;
    logic             ack_pulse;
    logic             accept;

    mcp_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ack_tog_async),
        .dout (ack_s)
    );

    always_comb begin
        ctl_d          = ctl_q;
        held_d         = held_q;
        ctl_d.ack_seen = ack_s;
        ack_pulse      = ack_s ^ ctl_q.ack_seen;
        accept         = send && (ctl_q.state == SRC_IDLE);
        unique case (ctl_q.state)
            SRC_IDLE: begin
                if (accept) begin
                    held_d        = word;
                    ctl_d.req_tog = ~ctl_q.req_tog;
                    ctl_d.state   = SRC_BUSY;
                end
            end
            SRC_BUSY: begin
                if (ack_pulse && (ack_s == ctl_q.req_tog)) begin
                    ctl_d.state = SRC_IDLE;
                end
            end
            default: ctl_d.state = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '{state: SRC_IDLE, req_tog: 1'b0, ack_seen: 1'b0};
            held_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            held_q <= held_d;
        end
    end

    assign ready     = (ctl_q.state == SRC_IDLE);
    assign req_tog   = ctl_q.req_tog;
    assign held_word = held_q;
endmodule

// File: rtl/mcp_dst_capture.sv
`timescale 1ns/1ps
module mcp_dst_capture
    import mcp_handoff_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tog_async,
    input  logic [WIDTH-1:0] word_async,
    output logic [WIDTH-1:0] word_out,
    output logic             valid_out,
    output logic             ack_tog
);
    dst_ctl_t         ctl_d, ctl_q;
    logic [WIDTH-1:0] word_d, word_q;
    logic             req_s;
    logic             load_now;

    mcp_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (req_tog_async),
        .dout (req_s)
    );

    always_comb begin
        ctl_d      = ctl_q;
        word_d     = word_q;
        load_now   = req_s ^ ctl_q.seen;
        ctl_d.seen = req_s;
        ctl_d.load = load_now;
        if (load_now) begin
            word_d = word_async;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '{seen: 1'b0, load: 1'b0};
            word_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            word_q <= word_d;
        end
    end

    assign word_out  = word_q;
    assign valid_out = ctl_q.load;
    assign ack_tog   = ctl_q.seen;
endmodule

// File: rtl/mcp_handoff.sv
`timescale 1ns/1ps
module mcp_handoff #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic             src_send,
    input  logic [WIDTH-1:0] src_word,
    output logic             src_ready,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic [WIDTH-1:0] dst_word,
    output logic             dst_valid
);
    logic             src_tog_w;
    logic [WIDTH-1:0] src_held_w;
    logic             dst_ack_w;

    mcp_src_ctrl #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk          (src_clk),
        .rst_n        (src_rst_n),
        .send         (src_send),
        .word         (src_word),
        .ack_tog_async(dst_ack_w),
        .ready        (src_ready),
        .req_tog      (src_tog_w),
        .held_word    (src_held_w)
    );

    mcp_dst_capture #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dst (
        .clk          (dst_clk),
        .rst_n        (dst_rst_n),
        .req_tog_async(src_tog_w),
        .word_async   (src_held_w),
        .word_out     (dst_word),
        .valid_out    (dst_valid),
        .ack_tog      (dst_ack_w)
    );
endmodule

// File: rtl/mcp_handoff_checker.sv
`timescale 1ns/1ps
module mcp_handoff_checker #(
    parameter int WIDTH = 16
) (
    input logic             src_clk,
    input logic             src_rst_n,
    input logic             src_send,
    input logic             src_ready,
    input logic             src_tog_w,
    input logic [WIDTH-1:0] src_held_w,
    input logic             dst_clk,
    input logic             dst_rst_n,
    input logic [WIDTH-1:0] dst_word,
    input logic             dst_valid
);
    AST_READY_DROP: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_send && src_ready) |=> !src_ready); // R3
    AST_TOGGLE_ON_ACCEPT: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_send && src_ready) |=> (src_tog_w != $past(src_tog_w))); // R3
    AST_IGNORED_SEND: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_send && !src_ready) |=> $stable(src_tog_w)); // R5
    AST_HOLD_WHILE_BUSY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !src_ready |=> $stable(src_held_w)); // R6
    AST_VALID_SINGLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_valid |=> !dst_valid); // R2
    AST_WORD_ONLY_ON_LOAD: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !$stable(dst_word) |-> dst_valid); // R2
    AST_CAPTURE_MATCH: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_valid |-> (dst_word == src_held_w)); // R1
endmodule

bind mcp_handoff mcp_handoff_checker #(.WIDTH(WIDTH)) u_checker (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_send  (src_send),
    .src_ready (src_ready),
    .src_tog_w (src_tog_w),
    .src_held_w(src_held_w),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_word  (dst_word),
    .dst_valid (dst_valid)
);

// File: tb/mcp_handoff_bench.sv
`timescale 1ns/1ps
module mcp_handoff_bench;
    localparam int W = 16;
    localparam int READY_LIMIT = 60;

    logic         src_clk = 1'b0;
    logic         dst_clk = 1'b0;
    logic         src_rst_n = 1'b0;
    logic         dst_rst_n = 1'b0;
    logic         src_send = 1'b0;
    logic [W-1:0] src_word = '0;
    logic         src_ready;
    logic [W-1:0] dst_word;
    logic         dst_valid;

    int           checks = 0;
    int           errors = 0;
    int           valid_cnt = 0;
    int           sends = 0;
    int           cyc = 0;
    logic [W-1:0] exp_word = '0;
    bit           pending = 1'b0;
    bit           done = 1'b0;

    always #5    src_clk = ~src_clk;
    always #6.5  dst_clk = ~dst_clk;

    mcp_handoff #(.WIDTH(W), .SYNC_STAGES(2)) u_mcp_handoff (
        .src_clk  (src_clk),
        .src_rst_n(src_rst_n),
        .src_send (src_send),
        .src_word (src_word),
        .src_ready(src_ready),
        .dst_clk  (dst_clk),
        .dst_rst_n(dst_rst_n),
        .dst_word (dst_word),
        .dst_valid(dst_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of the source holding register: loads only on an accepted send.
    function automatic logic [W-1:0] model_held(input logic [W-1:0] held,
                                                input bit accepted,
                                                input logic [W-1:0] offered);
        return accepted ? offered : held;
    endfunction

    always @(negedge dst_clk) begin
        if (dst_rst_n && dst_valid) begin
            valid_cnt++;
            chk(pending, "R2 pulse without accepted send", {15'd0, dst_valid}, '0);
            chk(dst_word == exp_word, "R1 captured word", dst_word, exp_word);
            pending = 1'b0;
        end
    end

    always @(posedge src_clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_ready(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < READY_LIMIT; i++) begin
            @(negedge src_clk);
            if (src_ready) begin
                ok = 1'b1;
                return;
            end
        end
    endtask

    task automatic transfer(input logic [W-1:0] word, input bit busy_send, input bit noise);
        bit ok;
        int cnt0;
        logic [W-1:0] held;
        wait_ready(ok);
        chk(ok, "R4 ready before send", {15'd0, src_ready}, 16'd1);
        cnt0 = valid_cnt;
        held = model_held(exp_word, 1'b1, word);
        src_send = 1'b1;
        src_word = word;
        exp_word = held;
        pending  = 1'b1;
        sends++;
        @(negedge src_clk);
        src_send = 1'b0;
        chk(src_ready == 1'b0, "R3 ready low after accept", {15'd0, src_ready}, '0);
        if (busy_send) begin
            src_send = 1'b1;
            src_word = ~word;
            held = model_held(held, 1'b0, ~word);
            @(negedge src_clk);
            src_send = 1'b0;
        end
        if (noise) begin
            src_word = W'($urandom);
            @(negedge src_clk);
            src_word = W'($urandom);
        end
        wait_ready(ok);
        chk(ok, "R4 ready returns within limit", {15'd0, src_ready}, 16'd1);
        chk(valid_cnt == cnt0 + 1, "R2/R5 one pulse per accepted send",
            W'(valid_cnt - cnt0), 16'd1);
        chk(dst_word == held, "R5/R6 delivered word unaffected", dst_word, held);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge src_clk);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        repeat (5) @(negedge src_clk);
        // R7 reset state
        chk(src_ready == 1'b1, "R7 ready after reset", {15'd0, src_ready}, 16'd1);
        chk(dst_valid == 1'b0, "R7 valid after reset", {15'd0, dst_valid}, '0);
        chk(dst_word == '0, "R7 word after reset", dst_word, '0);

        transfer(16'hA5C3, 1'b0, 1'b0);
        transfer(16'h0000, 1'b0, 1'b0);
        transfer(16'hFFFF, 1'b0, 1'b0);
        transfer(16'h1234, 1'b1, 1'b0);   // R5 send while busy
        transfer(16'h8001, 1'b0, 1'b1);   // R6 input noise in flight
        transfer(16'h8001, 1'b1, 1'b1);   // repeated word, both disturbances

        for (int n = 0; n < 40; n++) begin
            int gap;
            gap = int'($urandom_range(0, 5));
            repeat (gap) @(negedge src_clk);
            transfer(W'($urandom), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
        end

        repeat (20) @(negedge src_clk);
        chk(valid_cnt == sends, "R2 total pulses equal sends", W'(valid_cnt), W'(sends));
        chk(!pending, "R2 no outstanding transfer", {15'd0, pending}, '0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule